// File: doc/BRIEF.md
# Saturating Add/Subtract Unit

This block is the saturating arithmetic slice of a 32-bit integer execute stage. The issue logic hands it two register values, the two immediate fields already pulled out of the instruction word, the six-bit operation code and the destination register index. One clock edge later it presents a result clamped to the signed 32-bit range, the destination index, and four arithmetic flags: carry, overflow, sign and zero.

It also keeps a sticky saturation bit. Any operation that clamps sets this bit. Only an explicit status-word write can clear it. Software can therefore run a long chain of saturating operations and check once at the end whether any of them was clipped.

Register-file reads, instruction fetch and the decode of other instruction classes stay outside the block. An operation code that does not belong to the unit is ignored.

Top module: `satarith_unit`

## Requirements
- R1: The operation code selects one of five operations: 6'b000110 is register add, 6'b010001 is short-immediate add, 6'b000101 is subtract, 6'b000100 is reversed subtract and 6'b110011 is long-immediate subtract. Any other code produces no result and leaves result, flags and the sticky bit unchanged.
- R2: Register add computes `reg2_val + reg1_val`.
- R3: Short-immediate add computes `reg2_val` plus the 5-bit `imm_short`, sign-extended.
- R4: Subtract computes `reg2_val - reg1_val`. Reversed subtract computes `reg1_val - reg2_val`.
- R5: Long-immediate subtract computes `reg1_val` minus the 16-bit `imm_long`, sign-extended.
- R6: When the exact signed result exceeds 32'h7FFFFFFF, the result is 32'h7FFFFFFF. When it is below -2^31, the result is 32'h80000000. Otherwise the result is the exact value.
- R7: `flag_ov` is 1 exactly when the unclamped operation overflowed the signed 32-bit range. `flag_cy` is the carry out of bit 31 for additions. For subtractions it is the borrow, which is 1 when the minuend is below the subtrahend as unsigned numbers.
- R8: `flag_s` equals bit 31 of the clamped result, and `flag_z` is 1 exactly when the clamped result is zero.
- R9: `flag_sat` becomes 1 after any operation that clamps and stays 1 until a status write (`sat_wr_en`) loads `sat_wr_val`. If a status write and a clamping operation occur in the same cycle, the bit ends at 1.
- R10: `res_valid`, `result`, `res_dst` and all flags update on the clock edge that samples `op_valid`, so the latency is one cycle. `res_dst` repeats `op_dst`. After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 6 | Operation selector |
| reg1_val | input | 32 | First source register value |
| reg2_val | input | 32 | Second source register value, also the destination's old value |
| imm_short | input | 5 | Short immediate field |
| imm_long | input | 16 | Long immediate field |
| op_dst | input | 5 | Destination register index |
| sat_wr_en | input | 1 | Status-word write of the sticky bit |
| sat_wr_val | input | 1 | Value loaded by the status write |
| res_valid | output | 1 | Result present this cycle |
| result | output | 32 | Clamped result |
| res_dst | output | 5 | Destination register index of the result |
| flag_cy | output | 1 | Carry or borrow |
| flag_ov | output | 1 | Signed overflow before clamping |
| flag_s | output | 1 | Sign of the result |
| flag_z | output | 1 | Result is zero |
| flag_sat | output | 1 | Sticky saturation bit |

## Verification
The bench builds the unit with its default parameters: a 32-bit datapath, 5-bit and 16-bit immediates and a 5-bit register index. Every clamp boundary is therefore a real 32-bit limit, and the immediate sign-extension is exercised at its own widths. Directed cases place each operation on the limits 32'h7FFFFFFF, 32'h80000000, 0 and all ones, where carry, borrow, overflow and clamping separate from one another. Random operations, with operands drawn in part from those limits, are compared against a 64-bit exact model. That model also tracks the sticky bit across status writes, including writes in the same cycle as a clamping operation.

// File: rtl/satarith_pkg.sv
package satarith_pkg;
  localparam int unsigned OPC_W = 6;

  typedef enum logic [OPC_W-1:0] {
    OPC_ADD_RR  = 6'b000110,
    OPC_ADD_IS  = 6'b010001,
    OPC_SUB_RR  = 6'b000101,
    OPC_SUBR_RR = 6'b000100,
    OPC_SUB_IL  = 6'b110011
  } satop_e;

  typedef struct packed {
    logic cy;
    logic ov;
    logic s;
    logic z;
  } arith_flags_t;
endpackage

// File: rtl/satarith_decode.sv
module satarith_decode #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned IMM_S_W = 5,
  parameter int unsigned IMM_L_W = 16
) (
  input  logic [satarith_pkg::OPC_W-1:0] op_code,
  input  logic [DATA_W-1:0]              reg1_val,
  input  logic [DATA_W-1:0]              reg2_val,
  input  logic [IMM_S_W-1:0]             imm_short,
  input  logic [IMM_L_W-1:0]             imm_long,
  output logic [DATA_W-1:0]              opnd_a,
  output logic [DATA_W-1:0]              opnd_b,
  output logic                           do_sub,
  output logic                           known
);
  import satarith_pkg::*;

  localparam int unsigned EXT_S = DATA_W - IMM_S_W;
  localparam int unsigned EXT_L = DATA_W - IMM_L_W;

  logic [DATA_W-1:0] imm_s_ext;
  logic [DATA_W-1:0] imm_l_ext;

  assign imm_s_ext = {{EXT_S{imm_short[IMM_S_W-1]}}, imm_short};
  assign imm_l_ext = {{EXT_L{imm_long[IMM_L_W-1]}}, imm_long};

  always_comb begin
    opnd_a = reg2_val;
    opnd_b = reg1_val;
    do_sub = 1'b0;
    known  = 1'b1;
    case (op_code)
      OPC_ADD_RR:  begin opnd_a = reg2_val; opnd_b = reg1_val;  do_sub = 1'b0; end
      OPC_ADD_IS:  begin opnd_a = reg2_val; opnd_b = imm_s_ext; do_sub = 1'b0; end
      OPC_SUB_RR:  begin opnd_a = reg2_val; opnd_b = reg1_val;  do_sub = 1'b1; end
      OPC_SUBR_RR: begin opnd_a = reg1_val; opnd_b = reg2_val;  do_sub = 1'b1; end
      OPC_SUB_IL:  begin opnd_a = reg1_val; opnd_b = imm_l_ext; do_sub = 1'b1; end
      default:     known = 1'b0;
    endcase
  end
endmodule

// File: rtl/satarith_core.sv
module satarith_core #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0]        opnd_a,
  input  logic [DATA_W-1:0]        opnd_b,
  input  logic                     do_sub,
  output logic [DATA_W-1:0]        sat_res,
  output satarith_pkg::arith_flags_t flags,
  output logic                     clamped
);
  localparam int unsigned MSB = DATA_W - 1;
  localparam logic [DATA_W-1:0] POS_LIM = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] NEG_LIM = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0] b_eff;
  logic [DATA_W:0]   raw_sum;
  logic [DATA_W-1:0] raw;
  logic              carry_out;
  logic              ovf;

  assign b_eff     = do_sub ? ~opnd_b : opnd_b;
  assign raw_sum   = {1'b0, opnd_a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, do_sub};
  assign raw       = raw_sum[DATA_W-1:0];
  assign carry_out = raw_sum[DATA_W];
  assign ovf       = (opnd_a[MSB] == b_eff[MSB]) && (raw[MSB] != opnd_a[MSB]);

  always_comb begin
    sat_res = raw;
    if (ovf) sat_res = opnd_a[MSB] ? NEG_LIM : POS_LIM;
  end

  assign clamped  = ovf;
  assign flags.cy = do_sub ? ~carry_out : carry_out;
  assign flags.ov = ovf;
  assign flags.s  = sat_res[MSB];
  assign flags.z  = (sat_res == '0);
endmodule

// File: rtl/satarith_unit.sv
module satarith_unit #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned IMM_S_W = 5,
  parameter int unsigned IMM_L_W = 16,
  parameter int unsigned IDX_W   = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               op_valid,
  input  logic [5:0]         op_code,
  input  logic [DATA_W-1:0]  reg1_val,
  input  logic [DATA_W-1:0]  reg2_val,
  input  logic [IMM_S_W-1:0] imm_short,
  input  logic [IMM_L_W-1:0] imm_long,
  input  logic [IDX_W-1:0]   op_dst,
  input  logic               sat_wr_en,
  input  logic               sat_wr_val,
  output logic               res_valid,
  output logic [DATA_W-1:0]  result,
  output logic [IDX_W-1:0]   res_dst,
  output logic               flag_cy,
  output logic               flag_ov,
  output logic               flag_s,
  output logic               flag_z,
  output logic               flag_sat
);
  import satarith_pkg::*;

  localparam logic [DATA_W-1:0] POS_LIM = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] NEG_LIM = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0] opnd_a, opnd_b, sat_res;
  logic              do_sub, known, clamped;
  arith_flags_t      flg_d, flg_q;

  satarith_decode #(.DATA_W(DATA_W), .IMM_S_W(IMM_S_W), .IMM_L_W(IMM_L_W)) u_dec (
    .op_code(op_code), .reg1_val(reg1_val), .reg2_val(reg2_val),
    .imm_short(imm_short), .imm_long(imm_long),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .do_sub(do_sub), .known(known)
  );

  satarith_core #(.DATA_W(DATA_W)) u_core (
    .opnd_a(opnd_a), .opnd_b(opnd_b), .do_sub(do_sub),
    .sat_res(sat_res), .flags(flg_d), .clamped(clamped)
  );

  // next-state
  logic              fire;
  logic              sat_d;
  logic [DATA_W-1:0] res_q;
  logic [IDX_W-1:0]  dst_q;
  logic              vld_q, sat_q;

  assign fire = op_valid && known;

  always_comb begin
    sat_d = sat_q;
    if (sat_wr_en) sat_d = sat_wr_val;
    if (fire && clamped) sat_d = 1'b1;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      sat_q <= 1'b0;
    end else begin
      vld_q <= fire;
      sat_q <= sat_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      dst_q <= '0;
      flg_q <= '0;
    end else if (fire) begin
      res_q <= sat_res;
      dst_q <= op_dst;
      flg_q <= flg_d;
    end
  end

  assign res_valid = vld_q;
  assign result    = res_q;
  assign res_dst   = dst_q;
  assign flag_cy   = flg_q.cy;
  assign flag_ov   = flg_q.ov;
  assign flag_s    = flg_q.s;
  assign flag_z    = flg_q.z;
  assign flag_sat  = sat_q;

  // assertions
  assert_ov_clamps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && flag_ov) |-> (result == POS_LIM || result == NEG_LIM));

  assert_ov_sets_sat_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && flag_ov) |-> flag_sat);

  assert_sat_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_sat) |-> $past(sat_wr_en));

  assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> ($stable(result) && $stable(flag_cy) && $stable(flag_ov)
                    && $stable(flag_s) && $stable(flag_z)));

  assert_dst_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && known) |=> (res_valid && res_dst == $past(op_dst)));
endmodule

// File: tb/test_satarith_unit.sv
module test_satarith_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid;
  logic [5:0]  op_code;
  logic [31:0] reg1_val, reg2_val;
  logic [4:0]  imm_short;
  logic [15:0] imm_long;
  logic [4:0]  op_dst;
  logic        sat_wr_en, sat_wr_val;
  logic        res_valid;
  logic [31:0] result;
  logic [4:0]  res_dst;
  logic        flag_cy, flag_ov, flag_s, flag_z, flag_sat;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // model state
  logic [31:0] m_res;
  logic        m_cy, m_ov, m_s, m_z, m_sat;

  always #10 clk = ~clk;

  satarith_unit i_satarith_unit (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .reg1_val(reg1_val), .reg2_val(reg2_val), .imm_short(imm_short),
    .imm_long(imm_long), .op_dst(op_dst), .sat_wr_en(sat_wr_en),
    .sat_wr_val(sat_wr_val), .res_valid(res_valid), .result(result),
    .res_dst(res_dst), .flag_cy(flag_cy), .flag_ov(flag_ov), .flag_s(flag_s),
    .flag_z(flag_z), .flag_sat(flag_sat)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit is_known(input logic [5:0] c);
    return c == 6'b000110 || c == 6'b010001 || c == 6'b000101 ||
           c == 6'b000100 || c == 6'b110011;
  endfunction

  // exact 64-bit reference: updates model state
  task automatic model(input logic [5:0] c, input logic [31:0] r1, input logic [31:0] r2,
                       input logic [4:0] i5, input logic [15:0] i16, input bit wr, input bit wv);
    longint a, b, ex;
    logic [32:0] u;
    bit sub;
    a = 0; b = 0; sub = 0;
    case (c)
      6'b000110: begin a = longint'($signed(r2)); b = longint'($signed(r1)); end
      6'b010001: begin a = longint'($signed(r2)); b = longint'($signed(i5)); end
      6'b000101: begin a = longint'($signed(r2)); b = longint'($signed(r1)); sub = 1; end
      6'b000100: begin a = longint'($signed(r1)); b = longint'($signed(r2)); sub = 1; end
      6'b110011: begin a = longint'($signed(r1)); b = longint'($signed(i16)); sub = 1; end
      default: ;
    endcase
    if (wr) m_sat = wv;
    if (!is_known(c)) return;
    ex = sub ? a - b : a + b;
    m_ov = (ex > 64'sd2147483647) || (ex < -64'sd2147483648);
    if (ex > 64'sd2147483647) m_res = 32'h7FFFFFFF;
    else if (ex < -64'sd2147483648) m_res = 32'h80000000;
    else m_res = ex[31:0];
    if (sub) m_cy = (a[31:0] < b[31:0]);
    else begin
      u = {1'b0, a[31:0]} + {1'b0, b[31:0]};
      m_cy = u[32];
    end
    m_s = m_res[31];
    m_z = (m_res == 0);
    if (m_ov) m_sat = 1'b1;
  endtask

  task automatic run(input string req, input logic [5:0] c, input logic [31:0] r1,
                     input logic [31:0] r2, input logic [4:0] i5, input logic [15:0] i16,
                     input logic [4:0] d, input bit wr, input bit wv);
    @(negedge clk);
    op_valid = 1'b1; op_code = c; reg1_val = r1; reg2_val = r2;
    imm_short = i5; imm_long = i16; op_dst = d; sat_wr_en = wr; sat_wr_val = wv;
    model(c, r1, r2, i5, i16, wr, wv);
    @(posedge clk); #2;
    op_valid = 1'b0; sat_wr_en = 1'b0;
    chk({req, " R10 valid"}, res_valid, is_known(c));
    chk({req, " result"}, result, m_res);
    if (is_known(c)) chk({req, " R10 dst"}, res_dst, d);
    chk({req, " R7 cy"}, flag_cy, m_cy);
    chk({req, " R7 ov"}, flag_ov, m_ov);
    chk({req, " R8 s"}, flag_s, m_s);
    chk({req, " R8 z"}, flag_z, m_z);
    chk({req, " R9 sat"}, flag_sat, m_sat);
  endtask

  function automatic logic [31:0] pick();
    logic [31:0] v;
    case ($urandom % 8)
      0: v = 32'h7FFFFFFF;
      1: v = 32'h80000000;
      2: v = 32'h0;
      3: v = 32'hFFFFFFFF;
      default: v = $urandom;
    endcase
    return v;
  endfunction

  initial begin
    #3_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [5:0] codes [5];
    void'($urandom(32'd1234));
    codes[0] = 6'b000110; codes[1] = 6'b010001; codes[2] = 6'b000101;
    codes[3] = 6'b000100; codes[4] = 6'b110011;
    rst_n = 1'b0; op_valid = 1'b0; op_code = '0; reg1_val = '0; reg2_val = '0;
    imm_short = '0; imm_long = '0; op_dst = '0; sat_wr_en = 1'b0; sat_wr_val = 1'b0;
    m_res = '0; m_cy = 0; m_ov = 0; m_s = 0; m_z = 0; m_sat = 0;
    repeat (3) @(posedge clk);
    #2;
    // R10 reset state
    chk("R10 reset valid", res_valid, 0);
    chk("R10 reset result", result, 0);
    chk("R10 reset flags", {flag_cy, flag_ov, flag_s, flag_z, flag_sat}, 0);
    @(negedge clk); rst_n = 1'b1;

    // R2 register add, plain and positive clamp (R6)
    run("R2 add", 6'b000110, 32'd5, 32'd7, 0, 0, 5'd3, 0, 0);
    chk("R2 add value", result, 32'd12);
    run("R6 add pos clamp", 6'b000110, 32'd1, 32'h7FFFFFFF, 0, 0, 5'd4, 0, 0);
    chk("R6 pos limit", result, 32'h7FFFFFFF);
    // R9 sticky survives a clean op
    run("R9 sticky hold", 6'b000110, 32'd1, 32'd1, 0, 0, 5'd1, 0, 0);
    chk("R9 still set", flag_sat, 1);
    // R9 clear by write
    run("R9 clear", 6'b000110, 32'd0, 32'd0, 0, 0, 5'd2, 1, 0);
    chk("R9 cleared", flag_sat, 0);
    chk("R8 zero", flag_z, 1);
    // R3 short immediate: -1 + -1 and negative clamp
    run("R3 addi neg", 6'b010001, 0, 32'hFFFFFFFF, 5'h1F, 0, 5'd5, 0, 0);
    chk("R3 value", result, 32'hFFFFFFFE);
    run("R3 addi clamp", 6'b010001, 0, 32'h80000000, 5'h10, 0, 5'd6, 0, 0);
    chk("R6 neg limit", result, 32'h80000000);
    // R9 write and saturation together
    run("R9 wr vs sat", 6'b000101, 32'd1, 32'h80000000, 0, 0, 5'd7, 1, 0);
    chk("R9 sat wins", flag_sat, 1);
    // R4 subtract forms
    run("R4 sub", 6'b000101, 32'd3, 32'd10, 0, 0, 5'd8, 1, 0);
    chk("R4 sub value", result, 32'd7);
    run("R4 subr", 6'b000100, 32'd3, 32'd10, 0, 0, 5'd9, 0, 0);
    chk("R4 subr value", result, 32'hFFFFFFF9);
    chk("R7 borrow", flag_cy, 1);
    run("R4 sub 0-min", 6'b000101, 32'h80000000, 32'h0, 0, 0, 5'd10, 0, 0);
    chk("R6 0-min", result, 32'h7FFFFFFF);
    // R5 long immediate
    run("R5 subi", 6'b110011, 32'd100, 0, 0, 16'hFFFF, 5'd11, 0, 0);
    chk("R5 value", result, 32'd101);
    run("R5 subi clamp", 6'b110011, 32'h7FFFFFFF, 0, 0, 16'h8000, 5'd12, 0, 0);
    chk("R5 clamp", result, 32'h7FFFFFFF);
    // R1 unknown code ignored
    run("R1 unknown", 6'b111111, 32'h80000000, 32'h1, 0, 0, 5'd13, 0, 0);
    run("R1 unknown2", 6'b000111, 32'h1, 32'h1, 0, 0, 5'd14, 0, 0);

    for (int n = 0; n < 2000; n++) begin
      logic [5:0] c;
      c = ($urandom % 16 == 0) ? 6'($urandom) : codes[$urandom % 5];
      run("R6 random", c, pick(), pick(), 5'($urandom), 16'($urandom),
          5'($urandom), ($urandom % 10 == 0), 1'($urandom));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule